// File: doc/BRIEF.md
# Prescaled Countdown Timer with Auto-Reload

This block is a word-addressed countdown timer that sits behind a simple register bus. Software writes a start value and picks an 8-bit prescale divisor. After that the counter steps down once every divisor-plus-one clock cycles. When the count runs out, a sticky expiry flag is set and drives a level interrupt. The counter then either restarts from the stored reload value or parks at zero. One instance can serve as a periodic tick source and another as a watchdog-style one-shot.

The register window is 32 bytes wide and repeats across the address range. Four words in it are in use. Writes take effect only when all byte strobes are active. Read data is registered and appears one cycle after the read request.

Top module: `cdt_top`

## Requirements
- R1: Register select uses byte address bits [4:2], so the window repeats every 0x20 bytes. Word 0 (0x0) holds the reload value, word 1 (0x4) the counter, word 2 (0x8) control and word 3 (0xC) the expiry flag. Words 4 to 7 read as zero, and writes to them change nothing.
- R2: In the control word, bit 0 enables counting, bit 1 selects auto-reload and bits [15:8] hold the prescale value P. All other control bits read back as zero.
- R3: While enabled, the counter steps once every P+1 cycles. Writing the reload or counter word, or enabling the timer, restarts the prescale phase. A start value N then expires at the clock edge (P+1)*N edges after the one that took the write or the enable.
- R4: Writing the reload word sets both the reload value and the counter. Writing the counter word changes only the counter.
- R5: A control write that turns enable from 0 to 1, with auto-reload set in the written value and the counter at zero, first copies the reload value into the counter.
- R6: On expiry the flag is set. If auto-reload is clear, the counter stays at 0 and counting stops.
- R7: On expiry with auto-reload set, the counter takes the reload value in the same edge and keeps counting.
- R8: A read of the counter word returns 0 while the timer is disabled.
- R9: The expiry flag is read at bit 0 of word 3. Writing word 3 with bit 0 set clears the flag, and writing it with bit 0 clear leaves the flag alone. If an expiry and a clear land on the same edge, the flag stays set. The interrupt output equals the flag.
- R10: An enabled counter that holds zero does not change and produces no expiry.
- R11: A write with any byte strobe inactive is ignored.
- R12: Reset clears the reload value, counter, control and flag. Read data appears on the edge that follows the read request, and it holds the value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte strobes; all must be set |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, equal to the expiry flag |

## Verification
On every cycle, the assertions check that the flag stays set until an explicit clear, and that expiry sets the flag. They also check that the counter either reloads or parks at zero after expiry, that a zero counter stays idle, that writing the reload word lands in both registers, and that partial-strobe writes leave the reload value untouched. Other behaviours need the directed scenarios, compared against a behavioural reference model:
- the exact expiry cycle for several prescale values,
- the register readback and the window repetition,
- the copy of the reload value when the timer is enabled with a zero count,
- a clear that lands on the same edge as an expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned PRE_W        = 8;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_AR_BIT  = 1;
  localparam int unsigned CTRL_PRE_LSB = 8;
  localparam int unsigned WIN_WORDS    = 8;
  localparam int unsigned SEL_W        = $clog2(WIN_WORDS);

  typedef enum logic [SEL_W-1:0] {
    SEL_RELOAD = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_FLAG   = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pval,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic             hit;

  // >= keeps the phase bounded when P is lowered mid-count
  assign hit  = (div_q >= pval);
  assign tick = run && !restart && hit;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) div_q <= '0;
    else if (hit)               div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_ctrl,
  input  logic                      wr_flag,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      expire,
  output logic                      run,
  output logic                      autorl,
  output logic [cdt_pkg::PRE_W-1:0] pval,
  output logic                      flag,
  output logic                      en_rise
);
  import cdt_pkg::*;

  logic unused_wd;
  assign unused_wd = ^{wdata[DATA_W-1:CTRL_PRE_LSB+PRE_W], wdata[CTRL_PRE_LSB-1:CTRL_AR_BIT+1]};

  assign en_rise = wr_ctrl && !run && wdata[CTRL_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      autorl <= 1'b0;
      pval   <= '0;
    end else if (wr_ctrl) begin
      run    <= wdata[CTRL_EN_BIT];
      autorl <= wdata[CTRL_AR_BIT];
      pval   <= wdata[CTRL_PRE_LSB +: PRE_W];
    end
  end

  // expiry beats a same-edge clear
  always_ff @(posedge clk) begin
    if (rst)                     flag <= 1'b0;
    else if (expire)             flag <= 1'b1;
    else if (wr_flag && wdata[0]) flag <= 1'b0;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_reload,
  input  logic              wr_count,
  input  logic              fill_req,
  input  logic              tick,
  input  logic              autorl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire
);
  logic last_step;
  assign last_step = (cnt_q == DATA_W'(1));
  assign expire    = tick && !wr_reload && !wr_count && last_step;

  always_ff @(posedge clk) begin
    if (rst) reload_q <= '0;
    else if (wr_reload) reload_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_reload || wr_count) begin
      cnt_q <= wdata;
    end else if (fill_req && cnt_q == '0) begin
      cnt_q <= reload_q;
    end else if (tick && cnt_q != '0) begin
      if (last_step) cnt_q <= autorl ? reload_q : '0;
      else           cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cdt_top.sv
module cdt_top #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  output logic [DATA_W-1:0]     rdata,
  output logic                  irq_o
);
  import cdt_pkg::*;

  localparam int unsigned STRB_W  = DATA_W / 8;
  localparam int unsigned WIN_LSB = $clog2(STRB_W);
  localparam int unsigned WIN_MSB = WIN_LSB + SEL_W;

  logic [SEL_W-1:0]  sel;
  logic              wr_ok, wr_reload, wr_count, wr_ctrl, wr_flag;
  logic              run, autorl, flag, en_rise, tick, expire;
  logic [PRE_W-1:0]  pval;
  logic [DATA_W-1:0] reload_q, cnt_q, rd_val;
  logic              unused_addr;

  assign unused_addr = ^{addr[ADDR_W-1:WIN_MSB], addr[WIN_LSB-1:0]};

  assign sel       = addr[WIN_LSB +: SEL_W];
  assign wr_ok     = wr_en && (wstrb == '1);
  assign wr_reload = wr_ok && (sel == SEL_RELOAD);
  assign wr_count  = wr_ok && (sel == SEL_COUNT);
  assign wr_ctrl   = wr_ok && (sel == SEL_CTRL);
  assign wr_flag   = wr_ok && (sel == SEL_FLAG);

  cdt_ctrl_regs #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_flag(wr_flag), .wdata(wdata),
    .expire(expire), .run(run), .autorl(autorl), .pval(pval), .flag(flag),
    .en_rise(en_rise)
  );

  cdt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .run(run), .restart(wr_reload || wr_count),
    .pval(pval), .tick(tick)
  );

  cdt_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst(rst), .wr_reload(wr_reload), .wr_count(wr_count),
    .fill_req(en_rise && wdata[CTRL_AR_BIT]), .tick(tick), .autorl(autorl),
    .wdata(wdata), .reload_q(reload_q), .cnt_q(cnt_q), .expire(expire)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_RELOAD: rd_val = reload_q;
      SEL_COUNT:  rd_val = run ? cnt_q : '0;
      SEL_CTRL: begin
        rd_val[CTRL_EN_BIT]              = run;
        rd_val[CTRL_AR_BIT]              = autorl;
        rd_val[CTRL_PRE_LSB +: PRE_W]    = pval;
      end
      SEL_FLAG:   rd_val[0] = flag;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign irq_o = flag;
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [DATA_W/8-1:0] wstrb,
  input logic [DATA_W-1:0]   wdata,
  input logic [SEL_W-1:0]    sel,
  input logic                irq_o,
  input logic [DATA_W-1:0]   reload_q,
  input logic [DATA_W-1:0]   cnt_q,
  input logic                run,
  input logic                autorl,
  input logic                expire
);
  logic full_wr;
  assign full_wr = wr_en && (wstrb == '1);

  a_r9_sticky_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o && !(full_wr && sel == SEL_W'(3) && wdata[0]) |=> irq_o);

  a_r9_expiry_sets: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq_o);

  a_r6_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
    expire && !autorl |=> cnt_q == '0);

  a_r7_periodic_reload: assert property (@(posedge clk) disable iff (rst)
    expire && autorl |=> cnt_q == $past(reload_q));

  a_r10_zero_idle: assert property (@(posedge clk) disable iff (rst)
    run && cnt_q == '0 && !(full_wr && sel <= SEL_W'(2)) |=> cnt_q == '0);

  a_r10_zero_no_expiry: assert property (@(posedge clk) disable iff (rst)
    cnt_q == '0 |-> !expire);

  a_r4_reload_write: assert property (@(posedge clk) disable iff (rst)
    full_wr && sel == SEL_W'(0) |=> cnt_q == $past(wdata) && reload_q == $past(wdata));

  a_r11_partial_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en && wstrb != '1 |=> reload_q == $past(reload_q));
endmodule

bind cdt_top cdt_checker #(.DATA_W(DATA_W), .SEL_W(cdt_pkg::SEL_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wstrb(wstrb), .wdata(wdata), .sel(sel),
  .irq_o(irq_o), .reload_q(reload_q), .cnt_q(cnt_q), .run(run),
  .autorl(autorl), .expire(expire)
);

// File: tb/cdt_top_tb_top.sv
`timescale 1ns/1ps
module cdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int vectors = 0, fails = 0, cyc = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  cdt_top dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .irq_o(irq_o));

  // behavioural reference model
  int unsigned m_reload, m_cnt, m_pre, m_p, m_rd;
  bit m_en, m_ar, m_flag;

  always @(posedge clk) begin
    if (rst) begin
      m_reload = 0; m_cnt = 0; m_pre = 0; m_p = 0; m_rd = 0;
      m_en = 0; m_ar = 0; m_flag = 0;
    end else begin
      automatic bit ok = wr_en && (wstrb == 4'hF);
      automatic int w = int'(addr[4:2]);
      automatic bit old_en = m_en, old_ar = m_ar;
      automatic bit step = m_en && (m_pre >= m_p);
      automatic bit restart = ok && (w == 0 || w == 1);
      automatic bit fired = 1'b0;
      if (rd_en) begin
        if (w == 0) m_rd = m_reload;
        else if (w == 1) m_rd = m_en ? m_cnt : 0;
        else if (w == 2) m_rd = (m_p << 8) | (int'(m_ar) << 1) | int'(m_en);
        else if (w == 3) m_rd = int'(m_flag);
        else m_rd = 0;
      end
      if (restart) begin
        if (w == 0) m_reload = wdata;
        m_cnt = wdata;
      end else if (ok && w == 2 && !old_en && wdata[0] && wdata[1] && m_cnt == 0) begin
        m_cnt = m_reload;
      end else if (step && m_cnt != 0) begin
        if (m_cnt == 1) begin fired = 1'b1; m_cnt = old_ar ? m_reload : 0; end
        else m_cnt = m_cnt - 1;
      end
      if (!old_en || restart) m_pre = 0;
      else if (step) m_pre = 0;
      else m_pre = m_pre + 1;
      if (ok && w == 2) begin m_en = wdata[0]; m_ar = wdata[1]; m_p = wdata[15:8]; end
      if (fired) m_flag = 1'b1;
      else if (ok && w == 3 && wdata[0]) m_flag = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      vectors++;
      if (irq_o !== m_flag) begin
        fails++; $display("FAIL R9 model irq: actual %0b expected %0b", irq_o, m_flag);
      end
      vectors++;
      if (rdata !== m_rd) begin
        fails++; $display("FAIL R12 model rdata: actual %h expected %h", rdata, m_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wstrb = 4'h0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    live = 1'b1;

    // R12: reset state
    check("R12 irq after reset", {31'd0, irq_o}, 32'd0);
    bus_rd(12'h000, v); check("R12 reload after reset", v, 32'd0);
    bus_rd(12'h004, v); check("R12 counter after reset", v, 32'd0);
    bus_rd(12'h008, v); check("R12 control after reset", v, 32'd0);
    bus_rd(12'h00C, v); check("R12 flag after reset", v, 32'd0);

    // R2: control fields
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_rd(12'h008, v); check("R2 control readback", v, 32'h0000_FF03);
    bus_wr(12'h008, 32'h0);

    // R11 partial strobe, R1 unused words
    bus_wr(12'h000, 32'h0000_AAAA, 4'h3);
    bus_rd(12'h000, v); check("R11 partial strobe ignored", v, 32'd0);
    bus_wr(12'h010, 32'h5);
    bus_rd(12'h010, v); check("R1 unused word reads zero", v, 32'd0);
    bus_rd(12'h000, v); check("R1 unused word write ignored", v, 32'd0);

    // R4 / R8 / R1 alias
    bus_wr(12'h000, 32'h1234);
    bus_rd(12'h004, v); check("R8 counter read while disabled", v, 32'd0);
    bus_wr(12'h008, 32'h0000_FF01);
    bus_rd(12'h004, v); check("R4 reload write sets counter", v, 32'h1234);
    bus_rd(12'h020, v); check("R1 window repeats at 0x20", v, 32'h1234);
    bus_wr(12'h004, 32'h50);
    bus_rd(12'h000, v); check("R4 counter write keeps reload", v, 32'h1234);
    bus_rd(12'h004, v); check("R4 counter write value", v, 32'h50);
    bus_wr(12'h008, 32'h0);
    bus_rd(12'h004, v); check("R8 disabled again", v, 32'd0);

    // R10 zero counter idle, R5 fill on enable
    bus_wr(12'h000, 32'd7);
    bus_wr(12'h004, 32'd0);
    bus_wr(12'h008, 32'h1);
    idle(10);
    bus_rd(12'h004, v); check("R10 zero counter stays", v, 32'd0);
    check("R10 no expiry from zero", {31'd0, irq_o}, 32'd0);
    bus_wr(12'h008, 32'h0);
    bus_wr(12'h008, 32'h3);
    bus_rd(12'h004, v); check("R5 enable fills from reload", v, 32'd7);
    bus_wr(12'h008, 32'h0);

    // R3 / R6 one-shot, P=0, count 4
    bus_wr(12'h004, 32'd4);
    bus_wr(12'h008, 32'h1);
    idle(3);
    check("R3 no expiry before 4 edges", {31'd0, irq_o}, 32'd0);
    idle(1);
    check("R6 expiry at 4th edge", {31'd0, irq_o}, 32'd1);
    idle(5);
    bus_rd(12'h004, v); check("R6 one-shot parks at zero", v, 32'd0);
    check("R6 flag still set", {31'd0, irq_o}, 32'd1);

    // R9 write-one-to-clear
    bus_wr(12'h00C, 32'h0);
    check("R9 zero write keeps flag", {31'd0, irq_o}, 32'd1);
    bus_wr(12'h00C, 32'h1);
    check("R9 one write clears flag", {31'd0, irq_o}, 32'd0);
    bus_wr(12'h008, 32'h0);

    // R3 prescale P=2, R7 periodic reload 2
    bus_wr(12'h000, 32'd2);
    bus_wr(12'h008, 32'h0000_0203);
    idle(5);
    check("R3 P=2 no expiry at edge 5", {31'd0, irq_o}, 32'd0);
    idle(1);
    check("R3 P=2 expiry at edge 6", {31'd0, irq_o}, 32'd1);
    bus_wr(12'h00C, 32'h1);
    check("R9 cleared between periods", {31'd0, irq_o}, 32'd0);
    idle(4);
    check("R7 no second expiry yet", {31'd0, irq_o}, 32'd0);
    idle(1);
    check("R7 second period expiry", {31'd0, irq_o}, 32'd1);
    idle(5);
    bus_wr(12'h00C, 32'h1);   // lands on the third expiry edge
    check("R9 expiry wins over clear", {31'd0, irq_o}, 32'd1);

    bus_wr(12'h008, 32'h0);
    bus_rd(12'h004, v); check("R8 disabled counter reads zero", v, 32'd0);

    idle(2);
    live = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule